// File: doc/BRIEF.md
# Link Request Line Serializer

This block sits on the link-controller side of a serial bus physical layer. It drives the single-wire request line that the link uses to ask the physical layer for the bus, to read or write one of its registers, or to switch arbitration acceleration on or off. Each command arrives on a valid/ready interface. A command carries a type, a speed code, a 4-bit register address, a data byte and an acceleration enable. The block builds a frame whose length and layout depend on the type, shifts it out one bit per clock with the most significant bit first, and then returns the line low.

A bus request normally ends with a stop bit. When the last speed bit is 0, that stop bit may be dropped. A configuration input decides whether the block drops it. A command with the reserved type is refused: the block raises an error pulse and sends nothing. The block does not decide when to request the bus, and it does not read back status transfers.

Top module: `lreq_serializer`

## Requirements
- R1: Out of reset, and whenever no frame is in flight, the request line is 0, `cmd_ready_o` is 1 and `cmd_err_o` is 0.
- R2: Every frame sends 1 as frame bit 0, then the 3-bit type (000 immediate, 001 isochronous, 010 priority, 011 fair, 100 register read, 101 register write, 110 acceleration control) in bits 1 to 3, most significant bit first.
- R3: A bus request (types 000 to 011) sends the 3-bit speed in bits 4 to 6, most significant bit first, with 000, 010 and 100 as the three supported rates. It then sends a 0 stop bit in bit 7, for 8 bits in all.
- R4: When `short_stop_i` is 1 and speed bit 0 (frame bit 6) is 0, a bus request leaves out the stop bit and lasts 7 bits. Otherwise the stop bit is sent.
- R5: A register read sends the address in bits 4 to 7, most significant bit first, and a 0 stop bit in bit 8, for 9 bits.
- R6: A register write sends the address in bits 4 to 7, the data byte in bits 8 to 15 (both most significant bit first) and a 0 stop bit in bit 16, for 17 bits.
- R7: An acceleration-control request sends the enable in bit 4 and a 0 stop bit in bit 5, for 6 bits.
- R8: Frame bit 0 is on the line in the cycle after the handshake. `cmd_ready_o` is 0 from that cycle through the cycle of the last bit. In the next cycle the line is 0 and `cmd_ready_o` is 1.
- R9: A handshake with type 111 makes `cmd_err_o` 1 for exactly the next cycle. The line stays 0 and `cmd_ready_o` stays 1.
- R10: The speed field is sent unchanged even when it is not one of the supported codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Block idle, command accepted on valid and ready |
| cmd_type_i | input | 3 | Request type |
| cmd_speed_i | input | 3 | Bus request speed code |
| cmd_addr_i | input | 4 | Register address |
| cmd_data_i | input | 8 | Register write data |
| cmd_accel_i | input | 1 | Acceleration enable |
| short_stop_i | input | 1 | Drop the optional bus request stop bit when allowed |
| req_line_o | output | 1 | Serial request line |
| cmd_err_o | output | 1 | One-cycle pulse on a refused reserved-type command |

## Verification
The assertions check the cycle-level rules on every cycle. The line is low whenever the shifter is idle, an accepted command puts a 1 on the line and drops ready in the next cycle, and the line is low in the cycle ready returns. A reserved command must raise the error pulse without starting a frame. Only the bench scenarios can show that each frame's field order, bit values and exact length are right. This covers the optional-stop decision and speed codes outside the supported set, which the bench compares bit by bit against frames built independently.

// File: rtl/lreq_pkg.sv
package lreq_pkg;
  localparam int unsigned TYPE_W  = 3;
  localparam int unsigned SPEED_W = 3;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned FRAME_W = 1 + TYPE_W + ADDR_W + DATA_W + 1;
  localparam int unsigned LEN_W   = $clog2(FRAME_W + 1);

  typedef enum logic [TYPE_W-1:0] {
    REQ_IMM   = 3'b000,
    REQ_ISO   = 3'b001,
    REQ_PRI   = 3'b010,
    REQ_FAIR  = 3'b011,
    REQ_RD    = 3'b100,
    REQ_WR    = 3'b101,
    REQ_ACCEL = 3'b110,
    REQ_RSVD  = 3'b111
  } req_kind_e;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;  // bit 0 of the frame sits at the MSB
    logic [LEN_W-1:0]   len;
    logic               ok;
  } frame_t;
endpackage

// File: rtl/lreq_frame_build.sv
module lreq_frame_build
  import lreq_pkg::*;
(
  input  logic [TYPE_W-1:0]  type_i,
  input  logic [SPEED_W-1:0] speed_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               accel_i,
  input  logic               short_stop_i,
  output frame_t             frame_o
);
  localparam int unsigned BUS_PAD = FRAME_W - (1 + TYPE_W + SPEED_W + 1);
  localparam int unsigned RD_PAD  = FRAME_W - (1 + TYPE_W + ADDR_W + 1);
  localparam int unsigned ACC_PAD = FRAME_W - (1 + TYPE_W + 1 + 1);

  req_kind_e kind;
  assign kind = req_kind_e'(type_i);

  always_comb begin
    frame_o = '0;
    unique case (kind)
      REQ_IMM, REQ_ISO, REQ_PRI, REQ_FAIR: begin
        frame_o.bits = {1'b1, type_i, speed_i, 1'b0, {BUS_PAD{1'b0}}};
        // stop bit may only be dropped when the last speed bit is 0
        frame_o.len  = (short_stop_i && !speed_i[0]) ? LEN_W'(1 + TYPE_W + SPEED_W)
                                                     : LEN_W'(1 + TYPE_W + SPEED_W + 1);
        frame_o.ok   = 1'b1;
      end
      REQ_RD: begin
        frame_o.bits = {1'b1, type_i, addr_i, 1'b0, {RD_PAD{1'b0}}};
        frame_o.len  = LEN_W'(1 + TYPE_W + ADDR_W + 1);
        frame_o.ok   = 1'b1;
      end
      REQ_WR: begin
        frame_o.bits = {1'b1, type_i, addr_i, data_i, 1'b0};
        frame_o.len  = LEN_W'(FRAME_W);
        frame_o.ok   = 1'b1;
      end
      REQ_ACCEL: begin
        frame_o.bits = {1'b1, type_i, accel_i, 1'b0, {ACC_PAD{1'b0}}};
        frame_o.len  = LEN_W'(1 + TYPE_W + 2);
        frame_o.ok   = 1'b1;
      end
      default: frame_o = '0;
    endcase
  end
endmodule

// File: rtl/lreq_shift.sv
module lreq_shift #(
  parameter int unsigned W  = 17,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [W-1:0]  frame_i,
  input  logic [CW-1:0] len_i,
  output logic          line_o,
  output logic          busy_o
);
  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      line_q <= 1'b0;
    end else if (load_i) begin
      line_q <= frame_i[W-1];
      sh_q   <= {frame_i[W-2:0], 1'b0};
      cnt_q  <= len_i - CW'(1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        line_q <= 1'b0;
        busy_q <= 1'b0;
      end else begin
        line_q <= sh_q[W-1];
        sh_q   <= {sh_q[W-2:0], 1'b0};
        cnt_q  <= cnt_q - CW'(1);
      end
    end
  end

  assign line_o = line_q;
  assign busy_o = busy_q;

  // R1
  idle_line_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !line_q);
  // R8
  no_load_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_q);
  // R8
  done_line_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> !line_q);
endmodule

// File: rtl/lreq_serializer.sv
module lreq_serializer
  import lreq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic [TYPE_W-1:0]  cmd_type_i,
  input  logic [SPEED_W-1:0] cmd_speed_i,
  input  logic [ADDR_W-1:0]  cmd_addr_i,
  input  logic [DATA_W-1:0]  cmd_data_i,
  input  logic               cmd_accel_i,
  input  logic               short_stop_i,
  output logic               req_line_o,
  output logic               cmd_err_o
);
  frame_t frame;
  logic   busy, fire, load, err_q;

  lreq_frame_build u_build (
    .type_i       (cmd_type_i),
    .speed_i      (cmd_speed_i),
    .addr_i       (cmd_addr_i),
    .data_i       (cmd_data_i),
    .accel_i      (cmd_accel_i),
    .short_stop_i (short_stop_i),
    .frame_o      (frame)
  );

  assign cmd_ready_o = !busy;
  assign fire        = cmd_valid_i && cmd_ready_o;
  assign load        = fire && frame.ok;

  lreq_shift #(.W(FRAME_W), .CW(LEN_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .frame_i (frame.bits),
    .len_i   (frame.len),
    .line_o  (req_line_o),
    .busy_o  (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= fire && !frame.ok;
  end
  assign cmd_err_o = err_q;

  // R2
  start_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && cmd_type_i != REQ_RSVD) |=> req_line_o);
  // R8
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && cmd_type_i != REQ_RSVD) |=> !cmd_ready_o);
  // R9
  rsvd_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && cmd_type_i == REQ_RSVD) |=> (cmd_err_o && !req_line_o && cmd_ready_o));
  // R9
  err_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |=> !cmd_err_o);
  // R1
  ready_line_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_ready_o) |-> !req_line_o);
endmodule

// File: tb/lreq_serializer_bench.sv
module lreq_serializer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, ready, line, err, short_stop = 1'b0, accel = 1'b0;
  logic [2:0] typ = '0, speed = '0;
  logic [3:0] addr = '0;
  logic [7:0] data = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lreq_serializer u_lreq_serializer (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_ready_o(ready),
    .cmd_type_i(typ), .cmd_speed_i(speed), .cmd_addr_i(addr), .cmd_data_i(data),
    .cmd_accel_i(accel), .short_stop_i(short_stop), .req_line_o(line), .cmd_err_o(err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // frame bits collected in order: index 0 is the first bit on the line
  function automatic int exp_len(input logic [2:0] t, input logic [2:0] s, input bit sh);
    if (t[2] == 1'b0) return (sh && s[0] == 1'b0) ? 7 : 8;
    if (t == 3'b100) return 9;
    if (t == 3'b101) return 17;
    return 6;
  endfunction

  function automatic logic [16:0] exp_bits(input logic [2:0] t, input logic [2:0] s,
      input logic [3:0] a, input logic [7:0] d, input logic e);
    logic [16:0] b = '0;
    int p = 0;
    b[p++] = 1'b1;
    for (int i = 2; i >= 0; i--) b[p++] = t[i];
    if (t[2] == 1'b0) begin
      for (int i = 2; i >= 0; i--) b[p++] = s[i];
    end else if (t == 3'b110) begin
      b[p++] = e;
    end else begin
      for (int i = 3; i >= 0; i--) b[p++] = a[i];
      if (t == 3'b101) for (int i = 7; i >= 0; i--) b[p++] = d[i];
    end
    return b;  // remaining positions stay 0 (stop bit)
  endfunction

  function automatic string tag_of(input logic [2:0] t, input logic [2:0] s, input bit sh);
    if (t[2] == 1'b0) return (sh && !s[0]) ? "R4" : "R3";
    if (t == 3'b100) return "R5";
    if (t == 3'b101) return "R6";
    return "R7";
  endfunction

  task automatic do_cmd(input logic [2:0] t, input logic [2:0] s, input logic [3:0] a,
      input logic [7:0] d, input logic e, input bit sh);
    logic [16:0] got = '0, want;
    int n;
    bit rdy_bad = 1'b0;
    @(negedge clk);
    typ = t; speed = s; addr = a; data = d; accel = e; short_stop = sh; valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    if (t == 3'b111) begin
      check(err && !line && ready, "R9", {err, line, ready}, 3'b101);
      @(negedge clk);
      check(!err && !line, "R9", {err, line}, 2'b00);
      return;
    end
    n = exp_len(t, s, sh);
    want = exp_bits(t, s, a, d, e);
    for (int i = 0; i < n; i++) begin
      got[i] = line;
      if (ready) rdy_bad = 1'b1;
      @(negedge clk);
    end
    check(got[3:0] == want[3:0], "R2", got[3:0], want[3:0]);
    check(got == want, tag_of(t, s, sh), got, want);
    check(!rdy_bad, "R8", rdy_bad, 0);
    check(!line && ready, tag_of(t, s, sh), {line, ready}, 2'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1394));
    repeat (3) @(negedge clk);
    check(!line && ready && !err, "R1", {line, ready, err}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk);
    check(!line && ready && !err, "R1", {line, ready, err}, 3'b010);
    // directed corners
    do_cmd(3'b011, 3'b100, 4'h0, 8'h00, 1'b0, 1'b1);  // R4 short, 7 bits
    do_cmd(3'b011, 3'b100, 4'h0, 8'h00, 1'b0, 1'b0);  // R4 kept when disabled
    do_cmd(3'b000, 3'b011, 4'h0, 8'h00, 1'b0, 1'b1);  // R4 kept, bit 6 is 1 (R10)
    do_cmd(3'b001, 3'b111, 4'h0, 8'h00, 1'b0, 1'b0);  // R10 invalid speed
    do_cmd(3'b010, 3'b010, 4'h0, 8'h00, 1'b0, 1'b0);  // R3
    do_cmd(3'b100, 3'b000, 4'hA, 8'h00, 1'b0, 1'b1);  // R5
    do_cmd(3'b101, 3'b000, 4'h5, 8'hC3, 1'b0, 1'b1);  // R6
    do_cmd(3'b110, 3'b000, 4'h0, 8'h00, 1'b1, 1'b0);  // R7
    do_cmd(3'b110, 3'b000, 4'h0, 8'h00, 1'b0, 1'b0);  // R7
    do_cmd(3'b111, 3'b000, 4'hF, 8'hFF, 1'b1, 1'b0);  // R9
    check(!line && ready && !err, "R1", {line, ready, err}, 3'b010);
    for (int k = 0; k < 300; k++)
      do_cmd(3'($urandom), 3'($urandom), 4'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule